// File: doc/BRIEF.md
# SHA-512 Message Padder and Bit-Length Counter

This block sits in front of a SHA-512-family compression core. Message bytes come in one at a time over a valid/ready pair. The block packs them into a 128-byte buffer and hands each full buffer to the core as a single 1024-bit word over a block-valid/block-ready handshake. Alongside the packing it keeps a bit count of the message in two words, a low word and a high word. The high word takes the carry each time the low word wraps.

A finalise request ends the message. The block then appends the marker byte 0x80 and enough zero bytes to leave exactly sixteen bytes of room in the current block. It fills those sixteen bytes with the bit count, high word first. The count is frozen before any padding is written, so padding bytes are never counted. This yields one closing block, or two when the message ends too close to a block boundary. After the core accepts the closing block, `done` goes high. Further input is then refused until an `init` pulse starts a new message.

Top module: `sha512_pad_front`

## Requirements
- R1: After reset, and in the cycle after an `init` pulse, `in_ready` is 1, `done` is 0 and `blk_valid` is 0. Both length words are zero, and the next accepted byte lands at block byte 0.
- R2: Every 128 accepted bytes form one block. Byte k of the block (k = 0 first) appears on `blk_data[1023-8k -: 8]`. A block completed from message bytes alone carries `blk_last` = 0.
- R3: While `blk_valid` is 1 and `blk_ready` is 0, `in_ready` stays 0 and `blk_data`/`blk_last` hold their values.
- R4: When finalise is accepted with `fill` bytes in the buffer, the next byte written is 0x80. It is followed by (127 & (111 - fill)) zero bytes.
- R5: The last 16 bytes of the closing block are the high length word, then the low length word. Each is 64 bits, big-endian, and zero-extended from `LEN_W` bits.
- R6: The length advances by 8 for every accepted message byte and never for padding. When the low word wraps, the high word increments by one.
- R7: If fill is 112 or more at finalise, exactly two blocks follow the request. Only the second carries `blk_last` = 1.
- R8: If fill is 111 or less at finalise, exactly one block follows the request, and it carries `blk_last` = 1.
- R9: `done` rises in the cycle after the closing block is accepted. It stays high until `init`. While it is high, `in_ready` is 0, and neither bytes nor finalise requests have any effect.
- R10: If `fin_req` and `in_valid` are both high in an accepting cycle, finalise wins and the byte is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | One-cycle pulse that starts a new message |
| in_valid | input | 1 | Message byte present |
| in_data | input | 8 | Message byte |
| in_ready | output | 1 | Byte or finalise request accepted this cycle |
| fin_req | input | 1 | End-of-message request, held until accepted |
| blk_valid | output | 1 | Full block offered to the core |
| blk_ready | input | 1 | Core accepts the offered block |
| blk_data | output | 1024 | Block contents, byte 0 in the top bits |
| blk_last | output | 1 | Offered block is the closing block |
| done | output | 1 | Message fully handed off; digest may be read |

## Verification
The bound checker watches the per-cycle rules on every cycle: the offered block is held stable under backpressure, input is blocked while a block waits or after completion, the length words step by 8 with a carry into the high word and stay still during padding, and `init` brings the block back to a clean state. The byte placement, the 0x80 marker, the zero-run length and the trailer contents can only be shown by the scenarios. The bench compares whole blocks against a model for empty, short and boundary-length messages (111, 112, 127 and 128 bytes), for a long message whose low length word wraps, for the same-cycle finalise/byte collision, and for input presented after completion.

// File: rtl/sha512_pad_pkg.sv
// Shared constants and state encoding for the SHA-512 padding front end.
// Assumes a 128-byte block and a 16-byte length trailer.
package sha512_pad_pkg;
    localparam int BLK_BYTES = 128;
    localparam int TRL_BYTES = 16;
    localparam int BLK_W     = BLK_BYTES * 8;
    localparam int FILL_W    = $clog2(BLK_BYTES);
    localparam int TIDX_W    = $clog2(TRL_BYTES);
    localparam int WORD_W    = 64;
    localparam logic [7:0] PAD_LEAD = 8'h80;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_ZERO,
        ST_TRAIL,
        ST_FLUSH,
        ST_DONE
    } pad_state_e;
endpackage

// File: rtl/pad_lencnt.sv
// Bit-length counter kept as a low and a high word.
// Each increment adds 8 bits; the wrap of the low word carries into the high word.
// Assumes LEN_W >= 4.
module pad_lencnt #(
    parameter int LEN_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] len_hi,
    output logic [LEN_W-1:0] len_lo
);
    logic [LEN_W:0] lo_sum;

    // Low word plus one byte's worth of bits, with carry out on top.
    always_comb lo_sum = {1'b0, len_lo} + (LEN_W+1)'(8);

    // Count register update: clear, or add 8 bits and propagate carry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            len_lo <= '0;
            len_hi <= '0;
        end else if (inc) begin
            len_lo <= lo_sum[LEN_W-1:0];
            len_hi <= len_hi + LEN_W'(lo_sum[LEN_W]);
        end
    end
endmodule

// File: rtl/pad_blockbuf.sv
// 128-byte block buffer with fill counter and the outgoing block handshake.
// A write into the last slot raises blk_valid; writers must stall while it is high.
module pad_blockbuf
    import sha512_pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [7:0]        wr_byte,
    input  logic              wr_last,
    input  logic              blk_ready,
    output logic [FILL_W-1:0] fill,
    output logic              blk_valid,
    output logic              blk_last,
    output logic [BLK_W-1:0]  blk_data
);
    logic [7:0] mem [BLK_BYTES];

    // Byte storage: write the incoming byte at the current fill slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[fill] <= wr_byte;
    end

    // Fill pointer and block-offer flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fill      <= '0;
            blk_valid <= 1'b0;
            blk_last  <= 1'b0;
        end else begin
            if (blk_valid && blk_ready) blk_valid <= 1'b0;
            if (wr_en) begin
                fill <= fill + 1'b1;
                if (fill == FILL_W'(BLK_BYTES-1)) begin
                    blk_valid <= 1'b1;
                    blk_last  <= wr_last;
                end
            end
        end
    end

    // Flatten the byte array, byte 0 in the most significant position.
    for (genvar i = 0; i < BLK_BYTES; i++) begin : g_flat
        assign blk_data[BLK_W-1-8*i -: 8] = mem[i];
    end
endmodule

// File: rtl/pad_ctrl.sv
// Sequencer for message bytes, the 0x80 marker, the zero run and the length trailer.
// Emits one byte per cycle toward the buffer; stalls while a full block is pending.
module pad_ctrl
    import sha512_pad_pkg::*;
#(
    parameter int LEN_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              fin_req,
    input  logic [FILL_W-1:0] fill,
    input  logic              blk_pend,
    input  logic              blk_ready,
    input  logic [LEN_W-1:0]  len_hi,
    input  logic [LEN_W-1:0]  len_lo,
    output logic              in_ready,
    output logic              wr_en,
    output logic [7:0]        wr_byte,
    output logic              wr_last,
    output logic              cnt_en,
    output logic              done
);
    pad_state_e          state;
    logic [FILL_W-1:0]   zcnt;
    logic [TIDX_W-1:0]   tidx;
    logic [FILL_W-1:0]   zeros;
    logic [2*WORD_W-1:0] trail;

    // Zero-run length and trailer image derived from the current fill and count.
    always_comb begin
        zeros = FILL_W'(BLK_BYTES - TRL_BYTES - 1) - fill;
        trail = {WORD_W'(len_hi), WORD_W'(len_lo)};
    end

    assign in_ready = (state == ST_COLLECT) && !blk_pend;
    assign done     = (state == ST_DONE);

    // Byte source selection for the current state.
    always_comb begin
        wr_en   = 1'b0;
        wr_byte = 8'h00;
        wr_last = 1'b0;
        cnt_en  = 1'b0;
        unique case (state)
            ST_COLLECT: begin
                if (in_ready && fin_req) begin
                    wr_en   = 1'b1;
                    wr_byte = PAD_LEAD;
                end else if (in_ready && in_valid) begin
                    wr_en   = 1'b1;
                    wr_byte = in_data;
                    cnt_en  = 1'b1;
                end
            end
            ST_ZERO:  wr_en = !blk_pend;
            ST_TRAIL: begin
                wr_en   = !blk_pend;
                wr_byte = trail[8*(TRL_BYTES-1-int'(tidx)) +: 8];
                wr_last = (tidx == TIDX_W'(TRL_BYTES-1));
            end
            default: ;
        endcase
    end

    // State and counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            state <= ST_COLLECT;
            zcnt  <= '0;
            tidx  <= '0;
        end else begin
            unique case (state)
                ST_COLLECT: if (in_ready && fin_req) begin
                    zcnt  <= zeros;
                    tidx  <= '0;
                    state <= (zeros == '0) ? ST_TRAIL : ST_ZERO;
                end
                ST_ZERO: if (wr_en) begin
                    zcnt <= zcnt - 1'b1;
                    if (zcnt == FILL_W'(1)) state <= ST_TRAIL;
                end
                ST_TRAIL: if (wr_en) begin
                    tidx <= tidx + 1'b1;
                    if (wr_last) state <= ST_FLUSH;
                end
                ST_FLUSH: if (blk_pend && blk_ready) state <= ST_DONE;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sha512_pad_front.sv
// Top of the SHA-512 padding front end: byte intake, bit counting,
// padding, trailer and block hand-off to a compression core.
// LEN_W sets the stored width of each length word (zero-extended to 64 in the trailer).
module sha512_pad_front
    import sha512_pad_pkg::*;
#(
    parameter int LEN_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             fin_req,
    output logic             blk_valid,
    input  logic             blk_ready,
    output logic [BLK_W-1:0] blk_data,
    output logic             blk_last,
    output logic             done
);
    logic [FILL_W-1:0] fill;
    logic              wr_en, wr_last, cnt_en;
    logic [7:0]        wr_byte;
    logic [LEN_W-1:0]  len_hi, len_lo;

    pad_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .init(init),
        .in_valid(in_valid), .in_data(in_data), .fin_req(fin_req),
        .fill(fill), .blk_pend(blk_valid), .blk_ready(blk_ready),
        .len_hi(len_hi), .len_lo(len_lo),
        .in_ready(in_ready), .wr_en(wr_en), .wr_byte(wr_byte),
        .wr_last(wr_last), .cnt_en(cnt_en), .done(done)
    );

    pad_blockbuf u_buf (
        .clk(clk), .rst_n(rst_n), .clr(init),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_last(wr_last),
        .blk_ready(blk_ready), .fill(fill),
        .blk_valid(blk_valid), .blk_last(blk_last), .blk_data(blk_data)
    );

    pad_lencnt #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .clr(init), .inc(cnt_en),
        .len_hi(len_hi), .len_lo(len_lo)
    );
endmodule

// File: rtl/sha512_pad_front_chk.sv
// Protocol and counter checker for sha512_pad_front, attached by bind.
module sha512_pad_front_chk #(
    parameter int LEN_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init,
    input logic             in_ready,
    input logic             blk_valid,
    input logic             blk_ready,
    input logic [1023:0]    blk_data,
    input logic             blk_last,
    input logic             done,
    input logic             cnt_en,
    input logic [LEN_W-1:0] len_hi,
    input logic [LEN_W-1:0] len_lo
);
    p_init_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (in_ready && !done && !blk_valid && len_lo == '0 && len_hi == '0));

    p_stall_blocks_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> !in_ready);

    p_offer_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !blk_ready && !init) |=>
            (blk_valid && $stable(blk_data) && $stable(blk_last)));

    p_len_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !init) |=> (len_lo == LEN_W'($past(len_lo) + LEN_W'(8))));

    p_len_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !init) |=>
            ((len_hi == LEN_W'($past(len_hi) + 1'b1)) == (len_lo < $past(len_lo))));

    p_pad_not_counted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !init) |=> ($stable(len_lo) && $stable(len_hi)));

    p_done_refuses_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !init) |=> done);
endmodule

bind sha512_pad_front sha512_pad_front_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .init(init), .in_ready(in_ready),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .blk_last(blk_last), .done(done), .cnt_en(cnt_en),
    .len_hi(len_hi), .len_lo(len_lo)
);

// File: tb/sha512_pad_front_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: drivers model the padded stream and queue expected blocks,
// a monitor compares each block the core side accepts.
module sha512_pad_front_bench;
    localparam int LW = 10;  // reduced length word so the low word wraps in a short run

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready;
    logic fin_req = 1'b0;
    logic blk_valid;
    logic blk_ready = 1'b1;
    logic [1023:0] blk_data;
    logic blk_last;
    logic done;

    int n_tests = 0;
    int n_fail = 0;
    logic bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [1024:0] exp_q[$];
    string tag_q[$];
    string cur_tag = "R2";
    logic [7:0] mb [128];
    int mfill = 0;
    int lo_b = 0;
    int hi_b = 0;

    always #10 clk = ~clk;

    sha512_pad_front #(.LEN_W(LW)) u_sha512_pad_front (
        .clk(clk), .rst_n(rst_n), .init(init), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .fin_req(fin_req),
        .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
        .blk_last(blk_last), .done(done)
    );

    // Core-side readiness: always ready, or pseudo-random stalls.
    always begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        blk_ready = bp_en ? lfsr[0] : 1'b1;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic check(input bit ok, input string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    // Monitor: compare each accepted block with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && blk_valid) begin
            n_tests++;
            if (in_ready) begin
                n_fail++;
                $display("FAIL R3 in_ready actual=1 expected=0 while block pending");
            end
        end
        if (rst_n && blk_valid && blk_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, $sformatf("R9 unexpected block last=%0b expected none", blk_last));
            end else begin
                logic [1024:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({blk_last, blk_data} == e,
                      $sformatf("%s block actual last=%0b data=%h expected last=%0b data=%h",
                                t, blk_last, blk_data, e[1024], e[1023:0]));
            end
        end
    end

    // Model: place one byte in the expected stream, queue full blocks.
    task automatic model_byte(input logic [7:0] b, input bit last);
        mb[mfill] = b;
        mfill++;
        if (mfill == 128) begin
            logic [1024:0] v;
            v[1024] = last;
            for (int i = 0; i < 128; i++) v[1023-8*i -: 8] = mb[i];
            exp_q.push_back(v);
            tag_q.push_back(cur_tag);
            mfill = 0;
        end
    endtask

    // Wait at negedges until the DUT shows in_ready; acceptance is the following edge.
    task automatic wait_accept();
        bit acc;
        acc = 1'b0;
        while (!acc) begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = b;
        wait_accept();
        in_valid = 1'b0;
        model_byte(b, 1'b0);
        lo_b += 8;
        if (lo_b >= (1 << LW)) begin
            lo_b -= (1 << LW);
            hi_b++;
        end
    endtask

    task automatic send_msg(input int n, input int seed);
        for (int i = 0; i < n; i++) send_byte(8'((i * 37 + seed) & 8'hFF));
    endtask

    // Model of padding and trailer after the finalise request is taken.
    task automatic model_pad(input string tag);
        int z;
        logic [127:0] tr;
        cur_tag = tag;
        tr = {64'(hi_b), 64'(lo_b)};
        z = (111 - mfill) & 127;
        model_byte(8'h80, 1'b0);
        for (int i = 0; i < z; i++) model_byte(8'h00, 1'b0);
        for (int i = 0; i < 16; i++) model_byte(tr[127-8*i -: 8], i == 15);
        cur_tag = "R2";
    endtask

    task automatic wait_done(input string tag);
        int cyc;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check(done == 1'b1 && exp_q.size() == 0,
              $sformatf("%s done actual=%0b expected=1 pending=%0d", tag, done, exp_q.size()));
    endtask

    task automatic finish_msg(input string tag);
        @(posedge clk); #1;
        fin_req = 1'b1;
        wait_accept();
        fin_req = 1'b0;
        model_pad(tag);
        wait_done(tag);
    endtask

    task automatic do_init();
        @(posedge clk); #1;
        init = 1'b1;
        @(posedge clk); #1;
        init = 1'b0;
        mfill = 0; lo_b = 0; hi_b = 0;
        @(negedge clk);
        check(in_ready == 1'b1 && done == 1'b0 && blk_valid == 1'b0,
              $sformatf("R1 after init ready=%0b done=%0b valid=%0b expected 1/0/0",
                        in_ready, done, blk_valid));
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && done == 1'b0 && blk_valid == 1'b0,
              $sformatf("R1 reset ready=%0b done=%0b valid=%0b expected 1/0/0",
                        in_ready, done, blk_valid));

        // Empty message: marker, 111 zeros, zero trailer (R4 R5 R8).
        finish_msg("R8 empty R4 R5");
        do_init();

        // Short message.
        send_msg(3, 5);
        finish_msg("R4 R5 R8 short");
        do_init();

        // Boundary 111 bytes: single closing block, no zeros.
        send_msg(111, 9);
        finish_msg("R8 fill111");
        do_init();

        // Boundary 112 bytes: spill into a second block.
        send_msg(112, 3);
        finish_msg("R7 fill112");
        do_init();

        // 127 bytes: marker completes the block, closing block all padding.
        send_msg(127, 1);
        finish_msg("R7 fill127");
        do_init();

        // 128 bytes: full data block then a pure padding block.
        send_msg(128, 7);
        finish_msg("R2 R8 fill0");
        do_init();

        // Long message under backpressure; low length word wraps (R3 R6).
        bp_en = 1'b1;
        send_msg(300, 11);
        finish_msg("R6 R3 carry");
        bp_en = 1'b0;
        do_init();

        // Finalise and byte together: the byte is dropped (R10).
        send_msg(4, 2);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 8'h5A; fin_req = 1'b1;
        wait_accept();
        in_valid = 1'b0; fin_req = 1'b0;
        model_pad("R10 collision");
        wait_done("R10");

        // After done: bytes and finalise are refused (R9).
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 8'hEE; fin_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(in_ready == 1'b0 && done == 1'b1,
                  $sformatf("R9 after done ready=%0b done=%0b expected 0/1", in_ready, done));
        end
        @(posedge clk); #1;
        in_valid = 1'b0; fin_req = 1'b0;
        do_init();
        send_msg(5, 20);
        finish_msg("R9 R1 fresh message");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0,
              $sformatf("R2 leftover expected blocks actual=%0d expected=0", exp_q.size()));
        summary();
        $finish;
    end
endmodule